// File: doc/BRIEF.md
# DMA Request Flag Generator

This block turns per-trigger conversion-complete pulses into DMA request lines for eight trigger sources. Each trigger has an enable bit. When an enabled trigger finishes its conversion sequence, the block sets that trigger's status bit and raises its request line. The request line stays high until the DMA engine has serviced it.

Software reads and writes one 32-bit control word. The word holds the eight enable bits, the eight request status bits, a mode bit and a soft-reset bit. The status bits are cleared by writing 1 to them. The mode bit sets how a request is retired:

- Pulsed mode: the acknowledge alone drops the request.
- Latched mode: the request drops only after an acknowledge has been seen and the status bit has also been cleared.

Top module: `dma_req_gen`

## Requirements
- R1: After reset, dma_req_o is 0 and every bit of rd_data_o is 0.
- R2: Enable bit n of the control word (bits 7:0) is loaded on a write. An enabled done_i[n] pulse sets status bit 16+n and dma_req_o[n] on the next clock edge.
- R3: A done_i[n] pulse has no effect on status or request while enable bit n is 0.
- R4: A write with bit 16+n at 1 clears status bit n. Writing 0 to a status bit leaves it unchanged.
- R5: When a qualified done_i[n] and a write-1 clear of bit 16+n arrive in the same cycle, the status bit ends up set.
- R6: In latched mode (bit 30 = 0), dma_req_o[n] stays high until two things have happened, in either order: ack_i[n] has been seen while the request was high, and status bit 16+n has been cleared. It drops in the cycle the second of these takes effect.
- R7: In pulsed mode (bit 30 = 1), ack_i[n] alone drops dma_req_o[n] on the next edge, and status bit 16+n is left unchanged.
- R8: While soft-reset bit 31 reads 1, status, request and enable state are held at 0 and done_i pulses are ignored. The mode bit is kept.
- R9: The triggers are independent. Activity on one trigger never changes another trigger's status or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data for the control word |
| rd_data_o | output | 32 | Control word readback |
| done_i | input | 8 | Per-trigger conversion-complete pulse |
| ack_i | input | 8 | Per-trigger DMA acknowledge |
| dma_req_o | output | 8 | Per-trigger DMA request |

## Verification
Each trigger lane holds three pieces of state: the status bit, the request bit and a hidden "acknowledge seen" flag. A wrong status bit shows on rd_data_o one cycle after the offending edge. A wrong request bit shows on dma_req_o in that same cycle.

A stale or lost acknowledge-seen flag shows only in latched mode, and only later. It appears in the cycle software clears the status bit, when the request either fails to drop or drops too early. The bench therefore tests clear-before-ack, ack-before-clear, and set-versus-clear collisions.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned N_TRIG   = 8;
  localparam int unsigned DW       = 32;
  localparam int unsigned STAT_LSB = 16;
  localparam int unsigned MODE_BIT = 30;
  localparam int unsigned SRST_BIT = 31;
  typedef enum logic {MODE_LATCHED = 1'b0, MODE_PULSED = 1'b1} req_mode_e;
endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [N_TRIG-1:0] en_o,
  output logic [N_TRIG-1:0] w1c_o,
  output req_mode_e         mode_o,
  output logic              srst_o
);
  logic unused_wr;
  assign unused_wr = ^{wr_data_i[STAT_LSB-1:N_TRIG], wr_data_i[MODE_BIT-1:STAT_LSB+N_TRIG]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      mode_o <= MODE_LATCHED;
      srst_o <= 1'b0;
    end else begin
      if (wr_en_i) begin
        mode_o <= req_mode_e'(wr_data_i[MODE_BIT]);
        srst_o <= wr_data_i[SRST_BIT];
      end
      if (srst_o)       en_o <= '0;
      else if (wr_en_i) en_o <= wr_data_i[N_TRIG-1:0];
    end
  end

  assign w1c_o = wr_en_i ? wr_data_i[STAT_LSB +: N_TRIG] : '0;

  AST_SRST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> (en_o == '0)); // R8
endmodule

// File: rtl/dma_req_lane.sv
module dma_req_lane
  import dma_req_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      done_i,
  input  logic      en_i,
  input  logic      w1c_i,
  input  logic      ack_i,
  input  req_mode_e mode_i,
  input  logic      srst_i,
  output logic      status_o,
  output logic      req_o
);
  logic set, status_d, ackd_q, ackd_d, req_d, retire;

  assign set = done_i & en_i & ~srst_i;

  always_comb begin
    status_d = status_o;
    if (srst_i)     status_d = 1'b0;
    else if (set)   status_d = 1'b1;
    else if (w1c_i) status_d = 1'b0;
  end

  always_comb begin
    ackd_d = ackd_q;
    if (srst_i || set)       ackd_d = 1'b0;
    else if (req_o && ack_i) ackd_d = 1'b1;
  end

  // latched mode retires only once ack seen and status cleared
  assign retire = (mode_i == MODE_PULSED) ? ack_i : ((ackd_q | ack_i) & ~status_d);

  always_comb begin
    req_d = req_o;
    if (srst_i)      req_d = 1'b0;
    else if (set)    req_d = 1'b1;
    else if (retire) req_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= 1'b0;
      ackd_q   <= 1'b0;
      req_o    <= 1'b0;
    end else begin
      status_o <= status_d;
      ackd_q   <= ackd_d;
      req_o    <= req_d;
    end
  end

  AST_REQ_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(done_i && en_i)); // R2
  AST_NO_DONE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !status_o) |=> !status_o); // R3
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && en_i && !srst_i) |=> (status_o && req_o)); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LATCHED && req_o && status_o && !w1c_i && !srst_i) |=> req_o); // R6
  AST_PULSE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PULSED && req_o && ack_i && !(done_i && en_i) && !srst_i) |=> !req_o); // R7
  AST_SRST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!status_o && !req_o)); // R8
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic [N_TRIG-1:0] done_i,
  input  logic [N_TRIG-1:0] ack_i,
  output logic [N_TRIG-1:0] dma_req_o
);
  logic [N_TRIG-1:0] en, w1c, status;
  req_mode_e         mode;
  logic              srst;

  dma_req_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .en_o(en), .w1c_o(w1c), .mode_o(mode), .srst_o(srst)
  );

  for (genvar g = 0; g < N_TRIG; g++) begin : g_lane
    dma_req_lane u_lane (
      .clk_i, .rst_ni,
      .done_i(done_i[g]), .en_i(en[g]), .w1c_i(w1c[g]), .ack_i(ack_i[g]),
      .mode_i(mode), .srst_i(srst),
      .status_o(status[g]), .req_o(dma_req_o[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[N_TRIG-1:0]          = en;
    rd_data_o[STAT_LSB +: N_TRIG]  = status;
    rd_data_o[MODE_BIT]            = mode;
    rd_data_o[SRST_BIT]            = srst;
  end

  AST_REQ_IMPLIES_HIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o != $past(dma_req_o)) |-> ($past(srst) || $past(done_i != '0) || $past(ack_i != '0) || $past(wr_en_i))); // R9
endmodule

// File: tb/tb_dma_req_gen.sv
module tb_dma_req_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  done = '0, ack = '0, req;

  always #5ns clk = ~clk;

  dma_req_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .done_i(done), .ack_i(ack), .dma_req_o(req)
  );

  typedef struct { logic [7:0] req; logic [31:0] rd; string tag; } exp_t;
  exp_t q[$];
  int   checks = 0, fails = 0;
  bit   fin = 0;

  // requirement-level model state
  logic [7:0] m_en = '0, m_st = '0, m_req = '0, m_ackd = '0;
  logic m_mode = 0, m_srst = 0;

  task automatic step(input logic we, input logic [31:0] wd, input logic [7:0] dn,
                      input logic [7:0] ak, input string tag);
    exp_t e;
    logic [7:0] st_n, req_n, ackd_n;
    @(negedge clk);
    wr_en = we; wr_data = wd; done = dn; ack = ak;
    for (int i = 0; i < 8; i++) begin
      logic s, w;
      s = dn[i] & m_en[i] & ~m_srst;
      w = we & wd[16+i];
      st_n[i]   = m_srst ? 1'b0 : s ? 1'b1 : w ? 1'b0 : m_st[i];
      ackd_n[i] = (m_srst | s) ? 1'b0 : (m_req[i] & ak[i]) ? 1'b1 : m_ackd[i];
      if (m_srst)      req_n[i] = 1'b0;
      else if (s)      req_n[i] = 1'b1;
      else if (m_mode) req_n[i] = ak[i] ? 1'b0 : m_req[i];
      else             req_n[i] = ((m_ackd[i] | ak[i]) & ~st_n[i]) ? 1'b0 : m_req[i];
    end
    m_en   = m_srst ? 8'h00 : (we ? wd[7:0] : m_en);
    if (we) begin m_mode = wd[30]; m_srst = wd[31]; end
    m_st = st_n; m_req = req_n; m_ackd = ackd_n;
    e.req = m_req;
    e.rd  = {m_srst, m_mode, 6'b0, m_st, 8'b0, m_en};
    e.tag = tag;
    @(posedge clk);
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2ns;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (req !== e.req || rd_data !== e.rd) begin
        fails++;
        $display("FAIL %s: req=%h rd=%h expected req=%h rd=%h", e.tag, req, rd_data, e.req, e.rd);
      end
    end
  end

  initial begin
    #100us;
    if (!fin) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2ns;
    checks++;
    if (req !== 8'h00 || rd_data !== 32'h0) begin
      fails++;
      $display("FAIL R1: req=%h rd=%h expected 00 / 0", req, rd_data);
    end
    rst_ni = 1'b1;
    // R3: done with enables off ignored
    step(0, 0, 8'hFF, 0, "R3");
    // R2: enable triggers 0,3 (latched mode)
    step(1, 32'h0000_0009, 0, 0, "R2 en");
    step(0, 0, 8'h09, 0, "R2 set");
    // R3 / R9: done on disabled lane 1 leaves others
    step(0, 0, 8'h02, 0, "R3 R9");
    // R6: ack first, request held while status set
    step(0, 0, 0, 8'h01, "R6 ack");
    step(0, 0, 0, 0, "R6 hold");
    // R4: write 0 to status no effect
    step(1, 32'h0000_0009, 0, 0, "R4 w0");
    // R6: clear status -> drops lane 0 (ack seen), lane 3 stays
    step(1, 32'h0009_0009, 0, 0, "R6 R4 clr");
    // R6: lane 3 ack now, status already clear -> drop
    step(0, 0, 0, 8'h08, "R6 ack late");
    // R5: set and clear collide
    step(1, 32'h0001_0009, 8'h01, 0, "R5");
    step(1, 32'h0001_0009, 0, 0, "R5 clr");
    step(0, 0, 0, 8'h01, "R6 drop");
    // R7: pulsed mode
    step(1, 32'h4000_00F0, 0, 0, "R7 mode");
    step(0, 0, 8'hF0, 0, "R7 set");
    step(0, 0, 0, 8'h30, "R7 ack");
    step(0, 0, 0, 0, "R7 idle");
    step(0, 0, 0, 8'h0F, "R9 stray ack");
    // R8: soft reset
    step(1, 32'hC000_00F0, 0, 0, "R8 on");
    step(0, 0, 8'hFF, 0, "R8 held");
    step(1, 32'h8000_00FF, 8'hFF, 0, "R8 en blocked");
    step(1, 32'h4000_0004, 0, 0, "R8 off");
    step(0, 0, 8'h04, 0, "R8 R7 resume");
    step(0, 0, 0, 8'h04, "R7 ack2");
    step(0, 0, 0, 0, "R9 final");
    @(posedge clk); #4ns;
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule